// File: doc/BRIEF.md
# Two-Path Interrupt Steering Controller

This block collects a set of level-sensitive interrupt lines and hands each one to one of two processor inputs: a normal interrupt request (`irq_o`) or a fast interrupt request (`fiq_o`). Software chooses, per line, whether it takes part at all (the enable word) and which of the two outputs it feeds (the route word). Two read-only status words show the lines that are currently active, enabled and routed to each output.

For quick dispatch, the block also produces an encoded vector. This is the number of the lowest-numbered line that is reporting on the normal path. When nothing is reporting there, the lowest-numbered line on the fast path is used instead. A valid flag tells software whether any line is reporting at all.

Software reaches the block through a plain single-cycle register port: an address, a write strobe, write data, and read data that follows the address combinationally. The raw lines are sampled once per clock. A reported bit stays set for as long as its line is held high, and it drops only when the line goes low. No software clear exists.

Top module: `irq_steer_ctrl`

## Requirements
- R1: After reset the enable word and route word are zero, both status words read zero, the vector word reads zero, and `irq_o`, `fiq_o` and `vec_valid_o` are low.
- R2: A write with `bus_we_i` high loads word address 2 (enable, bit n for line n) or word address 3 (route, bit n = 1 sends line n to the fast path) at the clock edge, and the value reads back unchanged from the next cycle.
- R3: Writes to word addresses 0, 1 and 4 change no state: enable and route keep their values.
- R4: Each line is sampled into a register on every clock edge. Word address 0 reads the set of sampled-high lines that have enable 1 and route 0. Word address 1 reads the set of sampled-high lines that have enable 1 and route 1. No line appears in both words.
- R5: `irq_o` is high one cycle after the word-0 set is non-empty, and `fiq_o` is high one cycle after the word-1 set is non-empty.
- R6: `vec_idx_o` is the lowest set bit position of the word-0 set when that set is non-empty. Otherwise it is the lowest set bit position of the word-1 set. A normal-path line wins even when a fast-path line has a lower number.
- R7: When both sets are empty, `vec_valid_o` is 0, `vec_idx_o` is 0 and word address 4 reads zero.
- R8: Word address 4 reads `vec_valid_o` in bit 31 and `vec_idx_o` in bits 4:0, with all other bits zero.
- R9: A reported bit remains set for as long as its line stays high, and it clears once the line is sampled low.
- R10: Reads of word addresses 5, 6 and 7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Raw level-sensitive interrupt lines |
| bus_addr_i | input | 3 | Register word address |
| bus_we_i | input | 1 | Write strobe for the addressed word |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the addressed word (combinational) |
| irq_o | output | 1 | Normal interrupt request, registered |
| fiq_o | output | 1 | Fast interrupt request, registered |
| vec_valid_o | output | 1 | Some line is reporting on either path |
| vec_idx_o | output | 5 | Number of the selected line |

## Verification
The assertions check, on every cycle, the invariants that hold between the two status words and the enable and route words:
- the two status words never overlap;
- no disabled or mis-routed line is ever reported;
- the vector always points at a set bit with no lower set bit in the chosen word;
- the valid flag matches whether any line is reporting;
- each request pin follows its status word one cycle later;
- writes to read-only words leave state untouched.

Only the bench scenarios can show the rest, because these depend on concrete values and histories rather than on relations between signals:
- the reset values;
- the exact readback of written words;
- normal-path priority over a lower-numbered fast-path line;
- the bit-31 boundary;
- the zero readback of unmapped addresses;
- a held line staying reported over many cycles, then clearing.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    RA_IRQ_STAT = 3'd0,
    RA_FIQ_STAT = 3'd1,
    RA_ENABLE   = 3'd2,
    RA_ROUTE    = 3'd3,
    RA_VECTOR   = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/irq_steer_lsb.sv
// Lowest-set-bit encoder: found_o is high when any bit of vec_i is set,
// idx_o gives the position of the lowest set bit (0 when none is set).
module irq_steer_lsb #(
  parameter int N  = 32,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = |vec_i;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/irq_steer_regs.sv
// Software-written enable and route words.
// Writes to any other address leave both words unchanged.
module irq_steer_regs
  import irq_steer_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int DW   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [NSRC-1:0]   en_o,
  output logic [NSRC-1:0]   route_o
);
  logic [NSRC-1:0] en_q, route_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      route_q <= '0;
    end else if (we_i) begin
      if (addr_i == RA_ENABLE) en_q    <= wdata_i[NSRC-1:0];
      if (addr_i == RA_ROUTE)  route_q <= wdata_i[NSRC-1:0];
    end
  end

  assign en_o    = en_q;
  assign route_o = route_q;
endmodule

// File: rtl/irq_steer_route.sv
// Per-line sampling and steering into the two masked status words.
module irq_steer_route #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] en_i,
  input  logic [NSRC-1:0] route_i,
  output logic [NSRC-1:0] stat_irq_o,
  output logic [NSRC-1:0] stat_fiq_o
);
  for (genvar g = 0; g < NSRC; g++) begin : g_line
    logic pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= src_i[g];
    end

    assign stat_irq_o[g] = pend_q & en_i[g] & ~route_i[g];
    assign stat_fiq_o[g] = pend_q & en_i[g] &  route_i[g];
  end
endmodule

// File: rtl/irq_steer_ctrl.sv
module irq_steer_ctrl
  import irq_steer_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int DW   = 32,
  parameter int IDXW = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic [REG_AW-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  output logic              irq_o,
  output logic              fiq_o,
  output logic              vec_valid_o,
  output logic [IDXW-1:0]   vec_idx_o
);
  logic [NSRC-1:0] en_q, sel_q;
  logic [NSRC-1:0] stat_irq, stat_fiq;
  logic            irq_hit, fiq_hit;
  logic [IDXW-1:0] irq_idx, fiq_idx;
  logic            irq_q, fiq_q;

  irq_steer_regs #(.NSRC(NSRC), .DW(DW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .en_o    (en_q),
    .route_o (sel_q)
  );

  irq_steer_route #(.NSRC(NSRC)) u_route (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_i      (src_i),
    .en_i       (en_q),
    .route_i    (sel_q),
    .stat_irq_o (stat_irq),
    .stat_fiq_o (stat_fiq)
  );

  irq_steer_lsb #(.N(NSRC), .IW(IDXW)) u_lsb_irq (
    .vec_i   (stat_irq),
    .found_o (irq_hit),
    .idx_o   (irq_idx)
  );

  irq_steer_lsb #(.N(NSRC), .IW(IDXW)) u_lsb_fiq (
    .vec_i   (stat_fiq),
    .found_o (fiq_hit),
    .idx_o   (fiq_idx)
  );

  // The normal path takes precedence over the fast path.
  assign vec_valid_o = irq_hit | fiq_hit;
  assign vec_idx_o   = irq_hit ? irq_idx : (fiq_hit ? fiq_idx : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      fiq_q <= 1'b0;
    end else begin
      irq_q <= |stat_irq;
      fiq_q <= |stat_fiq;
    end
  end

  assign irq_o = irq_q;
  assign fiq_o = fiq_q;

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      RA_IRQ_STAT: bus_rdata_o[NSRC-1:0] = stat_irq;
      RA_FIQ_STAT: bus_rdata_o[NSRC-1:0] = stat_fiq;
      RA_ENABLE:   bus_rdata_o[NSRC-1:0] = en_q;
      RA_ROUTE:    bus_rdata_o[NSRC-1:0] = sel_q;
      RA_VECTOR: begin
        bus_rdata_o[DW-1]     = vec_valid_o;
        bus_rdata_o[IDXW-1:0] = vec_idx_o;
      end
      default:     bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_steer_ctrl_chk.sv
module irq_steer_ctrl_chk
  import irq_steer_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int DW   = 32,
  parameter int IDXW = $clog2(NSRC)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we_i,
  input logic [REG_AW-1:0] bus_addr_i,
  input logic [DW-1:0]     bus_wdata_i,
  input logic              irq_o,
  input logic              fiq_o,
  input logic              vec_valid_o,
  input logic [IDXW-1:0]   vec_idx_o,
  input logic [NSRC-1:0]   en_q,
  input logic [NSRC-1:0]   sel_q,
  input logic [NSRC-1:0]   stat_irq,
  input logic [NSRC-1:0]   stat_fiq
);
  logic [NSRC-1:0] chosen, below;

  always_comb begin
    chosen = (|stat_irq) ? stat_irq : stat_fiq;
    below  = (NSRC'(1) << vec_idx_o) - NSRC'(1);
  end

  p_enable_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we_i && bus_addr_i == RA_ENABLE) |=> en_q == $past(bus_wdata_i[NSRC-1:0]));

  p_ro_words_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we_i && (bus_addr_i == RA_IRQ_STAT || bus_addr_i == RA_FIQ_STAT || bus_addr_i == RA_VECTOR))
    |=> (en_q == $past(en_q) && sel_q == $past(sel_q)));

  p_disjoint_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_irq & stat_fiq) == '0);

  p_gated_routed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_irq | stat_fiq) & ~en_q) == '0 && (stat_irq & sel_q) == '0 && (stat_fiq & ~sel_q) == '0);

  p_irq_pin_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(|stat_irq)));

  p_fiq_pin_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (fiq_o == $past(|stat_fiq)));

  p_vec_lowest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> (chosen[vec_idx_o] && (chosen & below) == '0));

  p_vec_none_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid_o == |(stat_irq | stat_fiq)) && (!vec_valid_o -> vec_idx_o == '0));
endmodule

bind irq_steer_ctrl irq_steer_ctrl_chk #(.NSRC(NSRC), .DW(DW), .IDXW(IDXW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .irq_o       (irq_o),
  .fiq_o       (fiq_o),
  .vec_valid_o (vec_valid_o),
  .vec_idx_o   (vec_idx_o),
  .en_q        (en_q),
  .sel_q       (sel_q),
  .stat_irq    (stat_irq),
  .stat_fiq    (stat_fiq)
);

// File: tb/test_irq_steer_ctrl.sv
module test_irq_steer_ctrl;
  localparam int NSRC = 32;
  localparam int DW   = 32;
  localparam int AW   = 3;
  localparam int IDXW = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst_n;
  logic [NSRC-1:0] src;
  logic [AW-1:0]   addr;
  logic            we;
  logic [DW-1:0]   wdata;
  logic [DW-1:0]   rdata;
  logic            irq, fiq, vvalid;
  logic [IDXW-1:0] vidx;

  irq_steer_ctrl #(.NSRC(NSRC), .DW(DW)) i_irq_steer_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_i       (src),
    .bus_addr_i  (addr),
    .bus_we_i    (we),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq),
    .fiq_o       (fiq),
    .vec_valid_o (vvalid),
    .vec_idx_o   (vidx)
  );

  // Reference model state, updated only from the stimulus.
  logic [NSRC-1:0] m_en = '0, m_sel = '0, m_src = '0;

  // Scoreboard queues: expected read word, expected pins, check tag.
  logic [DW-1:0] q_rd[$];
  logic [7:0]    q_pin[$];
  string         q_tag[$];

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  function automatic int lowest(logic [NSRC-1:0] w);
    for (int i = 0; i < NSRC; i++) if (w[i]) return i;
    return -1;
  endfunction

  function automatic logic [NSRC-1:0] m_irq();
    return m_src & m_en & ~m_sel;
  endfunction

  function automatic logic [NSRC-1:0] m_fiq();
    return m_src & m_en & m_sel;
  endfunction

  function automatic int m_vec();
    if (m_irq() != '0) return lowest(m_irq());
    return lowest(m_fiq());
  endfunction

  function automatic logic [DW-1:0] m_word(int a);
    logic [DW-1:0] w;
    w = '0;
    case (a)
      0: w = m_irq();
      1: w = m_fiq();
      2: w = m_en;
      3: w = m_sel;
      4: if (m_vec() >= 0) w = 32'h8000_0000 | 32'(m_vec());
      default: w = '0;
    endcase
    return w;
  endfunction

  // Pins packed as {irq, fiq, valid, idx[4:0]}.
  function automatic logic [7:0] m_pins();
    int v;
    v = m_vec();
    return {|m_irq(), |m_fiq(), v >= 0, (v >= 0) ? 5'(v) : 5'd0};
  endfunction

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_read(int a, string tag);
    @(negedge clk);
    we   = 1'b0;
    addr = AW'(a);
    q_rd.push_back(m_word(a));
    q_pin.push_back(m_pins());
    q_tag.push_back(tag);
  endtask

  task automatic check_all(string tag);
    for (int a = 0; a < 5; a++) expect_read(a, tag);
  endtask

  task automatic write_reg(int a, logic [DW-1:0] d);
    @(negedge clk);
    addr  = AW'(a);
    wdata = d;
    we    = 1'b1;
    @(negedge clk);
    we = 1'b0;
    if (a == 2) m_en  = d;
    if (a == 3) m_sel = d;
    idle(2);
  endtask

  task automatic drive_src(logic [NSRC-1:0] d);
    @(negedge clk);
    src   = d;
    m_src = d;
    idle(2);
  endtask

  // Monitor: compares each expected item against the design outputs.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (q_rd.size() > 0) begin
        logic [DW-1:0] e_rd;
        logic [7:0]    e_pin, a_pin;
        string         t;
        e_rd  = q_rd.pop_front();
        e_pin = q_pin.pop_front();
        t     = q_tag.pop_front();
        a_pin = {irq, fiq, vvalid, vidx};
        n_vec++;
        if (rdata !== e_rd || a_pin !== e_pin) begin
          n_bad++;
          $display("FAIL %s addr=%0d rdata=%h expected=%h pins=%b expected=%b",
                   t, addr, rdata, e_rd, a_pin, e_pin);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    src   = '0;
    addr  = '0;
    we    = 1'b0;
    wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1: reset state of every word and pin
    check_all("R1 reset state");

    // R4: active lines with enable 0 are not reported
    drive_src(32'h0000_00F0);
    check_all("R4 disabled lines hidden");

    // R2: enable and route written and read back; R4/R5/R6 steering
    write_reg(2, 32'hFFFF_FFFF);
    write_reg(3, 32'h0000_00C0);
    check_all("R2 R4 R5 R6 R8 split steering");

    // R3: writes to read-only words leave state unchanged
    write_reg(0, 32'h1234_5678);
    write_reg(1, 32'hFFFF_0000);
    write_reg(4, 32'h0000_0000);
    check_all("R3 read-only writes ignored");

    // R10: unmapped words read zero
    expect_read(5, "R10 unmapped 5");
    expect_read(6, "R10 unmapped 6");
    expect_read(7, "R10 unmapped 7");

    // R6: fallback to fast path when normal path is empty
    drive_src(32'h0000_00C0);
    check_all("R6 fast-path fallback");

    // R6/R8: highest line number boundary on normal path
    drive_src(32'h8000_0000);
    check_all("R6 R8 line 31 boundary");

    // R6: normal path wins over a lower-numbered fast-path line
    write_reg(3, 32'h0000_0001);
    drive_src(32'h8000_0001);
    check_all("R6 normal path priority");

    // R9: held line stays reported across many cycles
    idle(6);
    check_all("R9 held line persists");

    // R2: partial enable masks one of the held lines
    write_reg(2, 32'h0000_0001);
    check_all("R2 R4 partial enable");

    // R7 R9: lines dropped, reports clear, vector invalid
    drive_src('0);
    check_all("R7 R9 all quiet");

    idle(3);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule